// File: doc/BRIEF.md
# Reservation Snoop and Store-Conditional Arbiter

This block holds the single load-reserve reservation of a local processor core and decides what happens to the core's later store-conditional. While a reservation is held, it compares write traffic from other masters on the local bus and on the system bus against the reserved word. It also accepts reservation-loss pulses from the bridges to the external bus and to the peripheral bus. Each intrusion is classified by a fixed table. The table's inputs are the bus on which the reserved location lives and the origin of the intruding master. The table's output is one of three actions.

A cancel action drops the reservation at once and pulses a cancel signal to the core. A block action marks the reservation so that the next store-conditional completes as failed without any bus cycle. A transfer action lets the store go out as a write-with-reservation on the system bus. The core then gets the reservation status sampled with the write's termination. A store-conditional that finds an intact reservation is forwarded in the same way. Every store-conditional that reaches its decision consumes the reservation. A change of the memory map configuration also discards it.

Top module: `resv_snoop_arb`

## Requirements
- R1: After reset no reservation is held. `sc_done`, `sc_success`, `cancel_resv` and `wr_req` are low, and a store-conditional issued next completes as blocked.
- R2: A load-reserve records its address and a bus code (0 local, 1 system, 2 external, 3 peripheral). With no intrusion, a store-conditional to any byte of the same 4-byte word raises `wr_req` on the second clock edge after `sc_req` is sampled, with `wr_addr` equal to the store address. `sc_success` then equals `wr_resv_ok` sampled together with `wr_ack`.
- R3: A new load-reserve replaces the previous reservation, so a store-conditional to the earlier word is blocked.
- R4: A store-conditional with no valid reservation, or to a different word, pulses `sc_done` on the second edge after `sc_req` is sampled. `sc_success` is low and `wr_req` never rises.
- R5: Intruder origins are as follows. The local snoop port is origin 0, the system snoop port is origin 1, `ext_resv_lost` is origin 2 and `per_resv_lost` is origin 3. Origin 2 or 3 on any reservation, and origin 1 on a system-bus reservation, cancel it. `cancel_resv` is high for the one cycle after the edge that samples the intrusion, and the next store-conditional is blocked.
- R6: Origin 0 on a local or system reservation, or origin 1 on a local reservation, gives no cancel pulse. The next store-conditional is blocked without `wr_req`.
- R7: Origin 0 or 1 on an external or peripheral reservation gives no cancel pulse. The next store-conditional is forwarded, and `sc_success` equals the sampled `wr_resv_ok`.
- R8: A snoop port counts only when its valid input is high and its address falls in the reserved word. Other snoop traffic leaves the reservation intact.
- R9: Every store-conditional that reaches its decision clears the reservation, whether it succeeds or not, so a second one is blocked.
- R10: `map_change` discards the reservation without a cancel pulse.
- R11: When several intrusions hit, in one cycle or across cycles, the strongest action is kept (cancel over block over transfer).
- R12: An intrusion sampled in the same cycle as `sc_req` is applied before the store-conditional is decided.
- R13: `wr_req` stays high with a stable `wr_addr` until `wr_ack`, and `sc_done` is a single-cycle pulse.
- R14: A load-reserve sampled in the same cycle as an intrusion installs a clean reservation. The intrusion is discarded and gives no cancel pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lr_valid | input | 1 | Load-reserve executed this cycle |
| lr_addr | input | ADDR_W | Load-reserve address |
| lr_bus | input | 2 | Bus holding the reserved location (0 local, 1 system, 2 external, 3 peripheral) |
| sc_req | input | 1 | Store-conditional request, accepted when idle |
| sc_addr | input | ADDR_W | Store-conditional address |
| sc_done | output | 1 | One-cycle completion pulse |
| sc_success | output | 1 | Store-conditional result, valid with `sc_done` |
| cancel_resv | output | 1 | Cancel-reservation pulse to the core |
| lb_snp_vld | input | 1 | Write by another local-bus master, address phase terminated normally |
| lb_snp_addr | input | ADDR_W | Address of that local-bus write |
| sb_snp_vld | input | 1 | Write by another system-bus master, address phase terminated normally |
| sb_snp_addr | input | ADDR_W | Address of that system-bus write |
| ext_resv_lost | input | 1 | External-bus bridge reports reservation lost |
| per_resv_lost | input | 1 | Peripheral-bus bridge reports reservation lost |
| map_change | input | 1 | Memory map configuration changed |
| wr_req | output | 1 | Write-with-reservation request on the system bus |
| wr_addr | output | ADDR_W | Address of that write |
| wr_ack | input | 1 | Termination of that write |
| wr_resv_ok | input | 1 | Reservation status sampled with `wr_ack` |

## Verification
The decision of a store-conditional and an incoming intrusion can fall in the same cycle. A load-reserve and an intrusion can also coincide. The bench drives `sc_req` together with a local snoop hit on a local reservation, and expects a blocked completion with no `wr_req`. It drives `sc_req` together with a system snoop hit on a system reservation, and expects a cancel pulse followed by a blocked completion. It also raises a load-reserve in the same cycle as a hit on the old word and a bridge loss pulse. It then checks that no cancel appears and that a store-conditional to the new word is forwarded.

// File: rtl/resv_pkg.sv
// Shared types of the reservation arbiter.
// Assumes the bus codes double as intruder-origin codes (same order).
package resv_pkg;

    typedef enum logic [1:0] {
        BUS_LOCAL  = 2'd0,
        BUS_SYSTEM = 2'd1,
        BUS_EXTERN = 2'd2,
        BUS_PERIPH = 2'd3
    } bus_id_e;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_CANCEL = 2'd1,
        ACT_BLOCK  = 2'd2,
        ACT_XFER   = 2'd3
    } sc_act_e;

    localparam int NUM_ORIGINS     = 4;
    localparam int NUM_SNOOP_BUSES = 2;

    // Severity of an action; a larger value overrides a smaller one.
    function automatic logic [1:0] act_rank(sc_act_e a);
        case (a)
            ACT_CANCEL: return 2'd3;
            ACT_BLOCK:  return 2'd2;
            ACT_XFER:   return 2'd1;
            default:    return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/resv_act_table.sv
// Decision table: maps (reserved-location bus, intruder origin) to the
// action applied to the next store-conditional.
// Assumes origin codes follow bus_id_e.
module resv_act_table
    import resv_pkg::*;
(
    input  bus_id_e resv_bus,
    input  bus_id_e origin,
    output sc_act_e action
);

    // Table lookup.
    always_comb begin
        case (origin)
            BUS_EXTERN, BUS_PERIPH: action = ACT_CANCEL;
            BUS_SYSTEM: begin
                if (resv_bus == BUS_SYSTEM)     action = ACT_CANCEL;
                else if (resv_bus == BUS_LOCAL) action = ACT_BLOCK;
                else                            action = ACT_XFER;
            end
            default: begin
                if (resv_bus == BUS_LOCAL || resv_bus == BUS_SYSTEM) action = ACT_BLOCK;
                else                                                 action = ACT_XFER;
            end
        endcase
    end

endmodule

// File: rtl/resv_snoop_cmp.sv
// Snoop comparator: flags a qualified write that lands in the reserved
// granule. Assumes snp_vld is raised only after a normally terminated
// address phase by a master other than the local core.
module resv_snoop_cmp #(
    parameter int ADDR_W   = 32,
    parameter int GRAN_LSB = 2
) (
    input  logic              snp_vld,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic              resv_valid,
    input  logic [ADDR_W-1:0] resv_addr,
    output logic              hit
);

    localparam int TAG_W = ADDR_W - GRAN_LSB;

    logic [TAG_W-1:0] snp_tag;
    logic [TAG_W-1:0] resv_tag;

    // Granule tags and compare.
    always_comb begin
        snp_tag  = snp_addr[ADDR_W-1:GRAN_LSB];
        resv_tag = resv_addr[ADDR_W-1:GRAN_LSB];
        hit      = snp_vld && resv_valid && (snp_tag == resv_tag);
    end

endmodule

// File: rtl/resv_tracker.sv
// Reservation register with intrusion classification.
// Holds valid/address/bus and the strongest pending action. Assumes the
// four intrusion sources arrive ordered as origins 0..3 (local snoop,
// system snoop, external bridge, peripheral bridge).
module resv_tracker
    import resv_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       lr_set,
    input  logic [ADDR_W-1:0]          lr_addr,
    input  bus_id_e                    lr_bus,
    input  logic [NUM_SNOOP_BUSES-1:0] bus_hit,
    input  logic                       ext_lost,
    input  logic                       per_lost,
    input  logic                       map_change,
    input  logic                       sc_clear,
    output logic                       resv_valid,
    output logic [ADDR_W-1:0]          resv_addr,
    output sc_act_e                    resv_lost_act,
    output logic                       cancel_pulse
);

    bus_id_e                resv_bus_q;
    logic [NUM_ORIGINS-1:0] src_hit;
    sc_act_e                src_act [NUM_ORIGINS];
    sc_act_e                worst_act;

    // Qualify every source with a held reservation.
    always_comb begin
        src_hit = {per_lost, ext_lost, bus_hit} & {NUM_ORIGINS{resv_valid}};
    end

    // One table lookup per intruder origin.
    for (genvar i = 0; i < NUM_ORIGINS; i++) begin : g_tbl
        localparam logic [1:0] ORG_CODE = 2'(i);
        resv_act_table u_tbl (
            .resv_bus (resv_bus_q),
            .origin   (bus_id_e'(ORG_CODE)),
            .action   (src_act[i])
        );
    end

    // Keep the strongest action among this cycle's intrusions.
    always_comb begin
        worst_act = ACT_NONE;
        for (int i = 0; i < NUM_ORIGINS; i++) begin
            if (src_hit[i] && (act_rank(src_act[i]) > act_rank(worst_act)))
                worst_act = src_act[i];
        end
    end

    // Reservation state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resv_valid    <= 1'b0;
            resv_addr     <= '0;
            resv_bus_q    <= BUS_LOCAL;
            resv_lost_act <= ACT_NONE;
            cancel_pulse  <= 1'b0;
        end else begin
            cancel_pulse <= (worst_act == ACT_CANCEL) && !lr_set;
            if (lr_set) begin
                resv_valid    <= 1'b1;
                resv_addr     <= lr_addr;
                resv_bus_q    <= lr_bus;
                resv_lost_act <= ACT_NONE;
            end else if (sc_clear || map_change || worst_act == ACT_CANCEL) begin
                resv_valid    <= 1'b0;
                resv_lost_act <= ACT_NONE;
            end else if (act_rank(worst_act) > act_rank(resv_lost_act)) begin
                resv_lost_act <= worst_act;
            end
        end
    end

    AST_CANCEL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        cancel_pulse |-> !resv_valid) else $error("cancel without drop"); // R5
    AST_MAP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (map_change && !lr_set) |=> !resv_valid) else $error("map change kept"); // R10
    AST_SC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_clear && !lr_set) |=> (!resv_valid && resv_lost_act == ACT_NONE)) else $error("sc kept"); // R9
    AST_LR_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
        lr_set |=> (resv_valid && resv_lost_act == ACT_NONE && !cancel_pulse)) else $error("lr not clean"); // R14
    AST_LOST_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        (resv_valid && $past(resv_valid) && !$past(lr_set))
        |-> (act_rank(resv_lost_act) >= act_rank($past(resv_lost_act)))) else $error("weakened"); // R11

endmodule

// File: rtl/sc_ctrl.sv
// Store-conditional sequencer: accepts a request when idle, decides in
// the next cycle from the reservation state, then either completes as
// failed at once or holds a write-with-reservation until it terminates.
// Assumes the core keeps at most one store-conditional outstanding.
module sc_ctrl
    import resv_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int GRAN_LSB = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sc_req,
    input  logic [ADDR_W-1:0] sc_addr,
    input  logic              resv_valid,
    input  logic [ADDR_W-1:0] resv_addr,
    input  sc_act_e           resv_lost_act,
    input  logic              wr_ack,
    input  logic              wr_resv_ok,
    output logic              sc_clear,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              sc_done,
    output logic              sc_success
);

    typedef enum logic [1:0] {ST_IDLE, ST_DECIDE, ST_WAIT} sc_state_e;

    sc_state_e         state;
    logic [ADDR_W-1:0] addr_q;
    logic              word_match;
    logic              sc_blocked;

    // Reuse the granule comparator for the store address.
    resv_snoop_cmp #(.ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB)) u_sc_cmp (
        .snp_vld    (1'b1),
        .snp_addr   (addr_q),
        .resv_valid (resv_valid),
        .resv_addr  (resv_addr),
        .hit        (word_match)
    );

    // Blocking decision and bus-side outputs.
    always_comb begin
        sc_blocked = !word_match || (resv_lost_act == ACT_BLOCK)
                     || (resv_lost_act == ACT_CANCEL);
        sc_clear   = (state == ST_DECIDE);
        wr_req     = (state == ST_WAIT);
        wr_addr    = addr_q;
    end

    // Sequencer and registered completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            addr_q     <= '0;
            sc_done    <= 1'b0;
            sc_success <= 1'b0;
        end else begin
            sc_done    <= 1'b0;
            sc_success <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (sc_req) begin
                        addr_q <= sc_addr;
                        state  <= ST_DECIDE;
                    end
                end
                ST_DECIDE: begin
                    if (sc_blocked) begin
                        sc_done <= 1'b1;
                        state   <= ST_IDLE;
                    end else begin
                        state <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (wr_ack) begin
                        sc_done    <= 1'b1;
                        sc_success <= wr_resv_ok;
                        state      <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        sc_done |=> !sc_done) else $error("done held"); // R13
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr))) else $error("write dropped"); // R13
    AST_BLOCK_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DECIDE && !resv_valid) |=> (sc_done && !sc_success && !wr_req)) else $error("no-resv sc"); // R4
    AST_NO_BUS_ON_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DECIDE && resv_lost_act == ACT_BLOCK) |=> !wr_req) else $error("blocked sc on bus"); // R6

endmodule

// File: rtl/resv_snoop_arb.sv
// Top: reservation snoop and store-conditional arbiter. Wires the two
// snoop comparators, the reservation tracker and the store-conditional
// sequencer. Assumes snoop and bridge inputs are single-cycle events.
module resv_snoop_arb
    import resv_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int GRAN_LSB = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lr_valid,
    input  logic [ADDR_W-1:0] lr_addr,
    input  logic [1:0]        lr_bus,
    input  logic              sc_req,
    input  logic [ADDR_W-1:0] sc_addr,
    output logic              sc_done,
    output logic              sc_success,
    output logic              cancel_resv,
    input  logic              lb_snp_vld,
    input  logic [ADDR_W-1:0] lb_snp_addr,
    input  logic              sb_snp_vld,
    input  logic [ADDR_W-1:0] sb_snp_addr,
    input  logic              ext_resv_lost,
    input  logic              per_resv_lost,
    input  logic              map_change,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_ack,
    input  logic              wr_resv_ok
);

    logic [NUM_SNOOP_BUSES-1:0] snp_vld;
    logic [ADDR_W-1:0]          snp_addr [NUM_SNOOP_BUSES];
    logic [NUM_SNOOP_BUSES-1:0] bus_hit;
    logic                       resv_valid;
    logic [ADDR_W-1:0]          resv_addr;
    sc_act_e                    resv_lost_act;
    logic                       sc_clear;

    // Snoop ports in origin order: local first, system second.
    always_comb begin
        snp_vld     = {sb_snp_vld, lb_snp_vld};
        snp_addr[0] = lb_snp_addr;
        snp_addr[1] = sb_snp_addr;
    end

    for (genvar b = 0; b < NUM_SNOOP_BUSES; b++) begin : g_snoop
        resv_snoop_cmp #(.ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB)) u_cmp (
            .snp_vld    (snp_vld[b]),
            .snp_addr   (snp_addr[b]),
            .resv_valid (resv_valid),
            .resv_addr  (resv_addr),
            .hit        (bus_hit[b])
        );
    end

    resv_tracker #(.ADDR_W(ADDR_W)) u_tracker (
        .clk           (clk),
        .rst_n         (rst_n),
        .lr_set        (lr_valid),
        .lr_addr       (lr_addr),
        .lr_bus        (bus_id_e'(lr_bus)),
        .bus_hit       (bus_hit),
        .ext_lost      (ext_resv_lost),
        .per_lost      (per_resv_lost),
        .map_change    (map_change),
        .sc_clear      (sc_clear),
        .resv_valid    (resv_valid),
        .resv_addr     (resv_addr),
        .resv_lost_act (resv_lost_act),
        .cancel_pulse  (cancel_resv)
    );

    sc_ctrl #(.ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB)) u_sc (
        .clk           (clk),
        .rst_n         (rst_n),
        .sc_req        (sc_req),
        .sc_addr       (sc_addr),
        .resv_valid    (resv_valid),
        .resv_addr     (resv_addr),
        .resv_lost_act (resv_lost_act),
        .wr_ack        (wr_ack),
        .wr_resv_ok    (wr_resv_ok),
        .sc_clear      (sc_clear),
        .wr_req        (wr_req),
        .wr_addr       (wr_addr),
        .sc_done       (sc_done),
        .sc_success    (sc_success)
    );

    AST_REQ_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> !sc_done) else $error("done while write open"); // R13

endmodule

// File: tb/resv_snoop_arb_tb.sv
module resv_snoop_arb_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lr_valid = 1'b0;
    logic [31:0] lr_addr = '0;
    logic [1:0]  lr_bus = '0;
    logic        sc_req = 1'b0;
    logic [31:0] sc_addr = '0;
    logic        sc_done, sc_success, cancel_resv, wr_req;
    logic [31:0] wr_addr;
    logic        lb_snp_vld = 1'b0;
    logic [31:0] lb_snp_addr = '0;
    logic        sb_snp_vld = 1'b0;
    logic [31:0] sb_snp_addr = '0;
    logic        ext_resv_lost = 1'b0;
    logic        per_resv_lost = 1'b0;
    logic        map_change = 1'b0;
    logic        wr_ack = 1'b0;
    logic        wr_resv_ok = 1'b0;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    resv_snoop_arb dut_i (
        .clk(clk), .rst_n(rst_n), .lr_valid(lr_valid), .lr_addr(lr_addr),
        .lr_bus(lr_bus), .sc_req(sc_req), .sc_addr(sc_addr), .sc_done(sc_done),
        .sc_success(sc_success), .cancel_resv(cancel_resv),
        .lb_snp_vld(lb_snp_vld), .lb_snp_addr(lb_snp_addr),
        .sb_snp_vld(sb_snp_vld), .sb_snp_addr(sb_snp_addr),
        .ext_resv_lost(ext_resv_lost), .per_resv_lost(per_resv_lost),
        .map_change(map_change), .wr_req(wr_req), .wr_addr(wr_addr),
        .wr_ack(wr_ack), .wr_resv_ok(wr_resv_ok)
    );

    // Vector: [7:6] reserved bus, [5:3] intruder origin (4 = none),
    // [2] wr_resv_ok returned, [1:0] expected: 0 intact, 1 cancel, 2 block, 3 transfer
    localparam logic [7:0] VEC [20] = '{
        8'b00_000_1_10, 8'b00_001_0_10, 8'b00_010_1_01, 8'b00_011_0_01, 8'b00_100_1_00,
        8'b01_000_1_10, 8'b01_001_0_01, 8'b01_010_1_01, 8'b01_011_0_01, 8'b01_100_0_00,
        8'b10_000_0_11, 8'b10_001_1_11, 8'b10_010_1_01, 8'b10_011_0_01, 8'b10_100_1_00,
        8'b11_000_1_11, 8'b11_001_0_11, 8'b11_010_0_01, 8'b11_011_1_01, 8'b11_100_0_00
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // All tasks start and end just after a falling edge.
    task automatic do_lr(input logic [31:0] a, input logic [1:0] bus);
        lr_valid = 1'b1; lr_addr = a; lr_bus = bus;
        @(negedge clk);
        lr_valid = 1'b0;
    endtask

    task automatic set_intr(input int src, input logic [31:0] a);
        case (src)
            0: begin lb_snp_vld = 1'b1; lb_snp_addr = a; end
            1: begin sb_snp_vld = 1'b1; sb_snp_addr = a; end
            2: ext_resv_lost = 1'b1;
            3: per_resv_lost = 1'b1;
            default: ;
        endcase
    endtask

    task automatic clr_intr();
        lb_snp_vld = 1'b0; sb_snp_vld = 1'b0;
        ext_resv_lost = 1'b0; per_resv_lost = 1'b0; map_change = 1'b0;
    endtask

    task automatic intrude(input int src, input logic [31:0] a,
                           input bit exp_cancel, input string req);
        set_intr(src, a);
        @(negedge clk);
        clr_intr();
        chk(cancel_resv == exp_cancel, req, "cancel_resv after intrusion", cancel_resv, exp_cancel);
    endtask

    // Check the outcome from the falling edge after the decision cycle.
    task automatic sc_outcome(input logic [31:0] a, input bit ok_in, input bit exp_fwd,
                              input int delay, input string req);
        if (!exp_fwd) begin
            chk(sc_done && !sc_success && !wr_req, req, "blocked sc {done,succ,wr_req}",
                {sc_done, sc_success, wr_req}, 3'b100);
        end else begin
            chk(wr_req && !sc_done && wr_addr == a, req, "forwarded write addr", wr_addr, a);
            for (int k = 0; k < delay; k++) begin
                @(negedge clk);
                chk(wr_req && !sc_done && wr_addr == a, "R13", "write held before ack", wr_addr, a);
            end
            wr_ack = 1'b1; wr_resv_ok = ok_in;
            @(negedge clk);
            wr_ack = 1'b0; wr_resv_ok = 1'b0;
            chk(sc_done && sc_success == ok_in && !wr_req, req, "forwarded sc result",
                {sc_done, sc_success, wr_req}, {1'b1, ok_in, 1'b0});
        end
        @(negedge clk);
        chk(!sc_done && !wr_req, "R13", "done is a single pulse", {sc_done, wr_req}, 2'b00);
    endtask

    task automatic do_sc(input logic [31:0] a, input bit ok_in, input bit exp_fwd,
                         input int delay, input string req);
        sc_req = 1'b1; sc_addr = a;
        @(negedge clk);
        sc_req = 1'b0;
        @(negedge clk);
        sc_outcome(a, ok_in, exp_fwd, delay, req);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not finish actual=0 expected=1");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!sc_done && !sc_success && !cancel_resv && !wr_req, "R1", "outputs in reset",
            {sc_done, sc_success, cancel_resv, wr_req}, 4'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!sc_done && !sc_success && !cancel_resv && !wr_req, "R1", "outputs after reset",
            {sc_done, sc_success, cancel_resv, wr_req}, 4'b0);
        do_sc(32'h0000_0100, 1'b1, 1'b0, 0, "R1");

        // Table walk: R2 intact, R5 cancel, R6 block, R7 transfer
        for (int i = 0; i < 20; i++) begin
            logic [31:0] a;
            logic [1:0]  bus;
            int          src;
            bit          okv;
            logic [1:0]  ex;
            string       tag;
            a   = 32'h0000_4000 + 32'(i * 16);
            bus = VEC[i][7:6];
            src = int'(VEC[i][5:3]);
            okv = VEC[i][2];
            ex  = VEC[i][1:0];
            tag = (ex == 2'd0) ? "R2" : (ex == 2'd1) ? "R5" : (ex == 2'd2) ? "R6" : "R7";
            do_lr(a, bus);
            if (src != 4) intrude(src, a | 32'h1, ex == 2'd1, tag);
            do_sc(a + 32'h2, okv, (ex == 2'd0) || (ex == 2'd3), 0, tag);
        end

        // R3: newer reservation replaces older
        do_lr(32'h0000_5000, 2'd0);
        do_lr(32'h0000_5100, 2'd0);
        do_sc(32'h0000_5000, 1'b1, 1'b0, 0, "R3");

        // R4: different word
        do_lr(32'h0000_5200, 2'd1);
        do_sc(32'h0000_5204, 1'b1, 1'b0, 0, "R4");

        // R8: snoop to a neighbouring word, and a matching address without valid
        do_lr(32'h0000_5300, 2'd0);
        intrude(0, 32'h0000_5304, 1'b0, "R8");
        sb_snp_addr = 32'h0000_5300;
        @(negedge clk);
        chk(!cancel_resv, "R8", "unqualified snoop", cancel_resv, 0);
        do_sc(32'h0000_5300, 1'b1, 1'b1, 0, "R8");

        // R9: reservation consumed by the first store-conditional
        do_lr(32'h0000_5400, 2'd0);
        do_sc(32'h0000_5400, 1'b0, 1'b1, 0, "R9");
        do_sc(32'h0000_5400, 1'b1, 1'b0, 0, "R9");

        // R10: map change drops without cancel
        do_lr(32'h0000_5500, 2'd1);
        map_change = 1'b1;
        @(negedge clk);
        clr_intr();
        chk(!cancel_resv, "R10", "no cancel on map change", cancel_resv, 0);
        do_sc(32'h0000_5500, 1'b1, 1'b0, 0, "R10");

        // R11: transfer and cancel in one cycle -> cancel
        do_lr(32'h0000_5600, 2'd2);
        set_intr(0, 32'h0000_5600);
        intrude(3, 32'h0000_5600, 1'b1, "R11");
        do_sc(32'h0000_5600, 1'b1, 1'b0, 0, "R11");
        // R11: block first, cancel later
        do_lr(32'h0000_5700, 2'd0);
        intrude(0, 32'h0000_5700, 1'b0, "R11");
        intrude(2, 32'h0000_5700, 1'b1, "R11");
        do_sc(32'h0000_5700, 1'b1, 1'b0, 0, "R11");

        // R12: intrusion in the request cycle (block case)
        do_lr(32'h0000_5800, 2'd0);
        sc_req = 1'b1; sc_addr = 32'h0000_5800;
        set_intr(0, 32'h0000_5800);
        @(negedge clk);
        sc_req = 1'b0; clr_intr();
        chk(!cancel_resv, "R12", "no cancel for block intrusion", cancel_resv, 0);
        @(negedge clk);
        sc_outcome(32'h0000_5800, 1'b1, 1'b0, 0, "R12");
        // R12: intrusion in the request cycle (cancel case)
        do_lr(32'h0000_5900, 2'd1);
        sc_req = 1'b1; sc_addr = 32'h0000_5900;
        set_intr(1, 32'h0000_5900);
        @(negedge clk);
        sc_req = 1'b0; clr_intr();
        chk(cancel_resv, "R12", "cancel in request cycle", cancel_resv, 1);
        @(negedge clk);
        sc_outcome(32'h0000_5900, 1'b1, 1'b0, 0, "R12");

        // R13: delayed termination
        do_lr(32'h0000_5A00, 2'd3);
        do_sc(32'h0000_5A00, 1'b1, 1'b1, 3, "R13");

        // R14: load-reserve with same-cycle intrusion on the old word
        do_lr(32'h0000_5B00, 2'd0);
        set_intr(0, 32'h0000_5B00);
        set_intr(2, 32'h0000_5B00);
        do_lr(32'h0000_5C00, 2'd0);
        clr_intr();
        chk(!cancel_resv, "R14", "no cancel with load-reserve", cancel_resv, 0);
        do_sc(32'h0000_5C00, 1'b1, 1'b1, 0, "R14");

        summary();
        $finish;
    end

endmodule